// File: doc/BRIEF.md
# Oversampling Serial Receiver with Majority Vote and Noise Flag

This block receives asynchronous serial frames on a single line. The line is passed through a two-flop synchronizer, and the block looks at it only on cycles where an external oversample enable is high. A bit period is either 16 or 8 of these enables long, chosen by a mode input. Each bit is decided by majority over three consecutive samples near the middle of the bit. A noise flag is raised for the frame if any bit's three samples disagree.

A frame has a low start bit, then 8 or 9 data bits sent least significant bit first, then an optional parity bit, then one stop bit. When the stop bit has been sampled, the result goes into a one-deep holding register. This sets a buffer-full flag, and a read strobe clears it again. Separate status bits report noise, parity, framing and overrun for the held frame. Receive enable gates both start detection and any frame in progress.

Top module: `os_uart_rx`

## Requirements
- R1: With `rx_en` low, a low line starts no frame and nothing is delivered. With `rx_en` high and the receiver idle, a low line seen on an oversample enable marks sample 1 of a start bit.
- R2: In 16x mode (`ovs8`=0), each bit's value is the majority of its samples 8, 9 and 10. A sample at any other position does not change the result.
- R3: In 8x mode (`ovs8`=1), each bit's value is the majority of its samples 3, 4 and 5.
- R4: `err_noise` is set for a delivered frame when, for at least one bit of that frame (start, data, parity or stop), the three voting samples were not all equal.
- R5: When `pen`=1, a parity bit follows the data bits. The XOR of the data bits and the parity bit must be 0 when `podd`=0 and 1 when `podd`=1. Otherwise `err_parity` is set. When `pen`=0, `err_parity` stays 0.
- R6: A stop bit that votes 0 sets `err_frame`, and the data is still stored.
- R7: When a frame completes with `rbne` low, `rx_data` takes the data bits (bit 0 first on the line; 8 bits when `wl`=0 with bit 8 reading 0, 9 bits when `wl`=1), and `rbne` rises. After reset, `rbne` and all error flags are 0.
- R8: A one-cycle `rd` pulse clears `rbne` and `err_overrun` on the next clock edge.
- R9: If a frame completes while `rbne` is high and `rd` is low, `err_overrun` is set, the new frame is dropped, and `rx_data` keeps the older value.
- R10: A start bit whose vote is 1 is a false start. The receiver returns to idle, delivers nothing, and then accepts the next frame normally.
- R11: Dropping `rx_en` during a frame abandons that frame. Nothing is delivered, even after `rx_en` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| os_tick | input | 1 | Oversample enable, one pulse per sample |
| rx | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable |
| ovs8 | input | 1 | 1: 8 samples per bit, 0: 16 samples per bit |
| wl | input | 1 | 1: 9 data bits, 0: 8 data bits |
| pen | input | 1 | Parity bit present |
| podd | input | 1 | 1: odd parity, 0: even parity |
| rd | input | 1 | Read strobe for the data register |
| rx_data | output | DATA_W | Held frame data |
| rbne | output | 1 | Holding register full |
| err_noise | output | 1 | Noise seen in held frame |
| err_parity | output | 1 | Parity mismatch in held frame |
| err_frame | output | 1 | Stop bit read as 0 in held frame |
| err_overrun | output | 1 | A frame was dropped because the register was full |

## Verification
The line goes through two synchronizer flops, so the bench changes `rx` three clock edges before each oversample enable it wants that value to meet. The vote for a bit is taken on the enable of its third voting sample. The framer registers the frame result on that edge, and `rbne`, the data and the flags change on the following edge, so they are due two clocks after the stop bit's last voting sample. The bench checks them only after the whole stop bit and twelve idle samples have passed, well after that point. A read clears `rbne` one edge after `rd`, and all checks are taken on falling edges.

// File: rtl/os_uart_rx_pkg.sv
package os_uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic noise;
    logic parity;
    logic frame;
  } rx_err_t;
endpackage

// File: rtl/os_uart_rx_sync.sv
module os_uart_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/os_uart_rx_sampler.sv
module os_uart_rx_sampler #(
  parameter int CNT_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ovs8,
  input  logic rx,
  input  logic active,
  output logic start_seen,
  output logic bit_done,
  output logic bit_val,
  output logic bit_noise
);
  localparam logic [CNT_W-1:0] LEN16 = CNT_W'(16);
  localparam logic [CNT_W-1:0] LEN8  = CNT_W'(8);
  localparam logic [CNT_W-1:0] MID16 = CNT_W'(9);
  localparam logic [CNT_W-1:0] MID8  = CNT_W'(4);

  logic [CNT_W-1:0] cnt_q, cnt_d, cur, len, pos_first, pos_last;
  logic [1:0]       smp_q, smp_d;

  always_comb begin
    len       = ovs8 ? LEN8 : LEN16;
    pos_first = (ovs8 ? MID8 : MID16) - CNT_W'(1);
    pos_last  = (ovs8 ? MID8 : MID16) + CNT_W'(1);
    cur       = (cnt_q >= len) ? CNT_W'(1) : cnt_q + CNT_W'(1);
    start_seen = tick && !active && !rx;
    bit_done   = tick && active && (cur == pos_last);
    bit_val    = (smp_q[1] & smp_q[0]) | (smp_q[1] & rx) | (smp_q[0] & rx);
    bit_noise  = !((smp_q[1] == smp_q[0]) && (smp_q[0] == rx));
  end

  always_comb begin
    cnt_d = cnt_q;
    smp_d = smp_q;
    if (tick) begin
      if (!active) begin
        cnt_d = start_seen ? CNT_W'(1) : '0;
      end else begin
        cnt_d = cur;
        if (cur >= pos_first && cur < pos_last) smp_d = {smp_q[0], rx};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      smp_q <= 2'b11;
    end else begin
      cnt_q <= cnt_d;
      smp_q <= smp_d;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LEN16);
  p_vote_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> !bit_done);
endmodule

// File: rtl/os_uart_rx_framer.sv
module os_uart_rx_framer
  import os_uart_rx_pkg::*;
#(
  parameter int DATA_W = 9,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              wl,
  input  logic              pen,
  input  logic              podd,
  input  logic              start_seen,
  input  logic              bit_done,
  input  logic              bit_val,
  input  logic              bit_noise,
  output logic              active,
  output logic              fr_done,
  output logic [DATA_W-1:0] fr_data,
  output rx_err_t           fr_err
);
  rx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d, last_idx;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic              noise_q, noise_d, par_q, par_d, done_q, done_d;
  rx_err_t           err_q, err_d;

  always_comb begin
    last_idx = wl ? IDX_W'(DATA_W-1) : IDX_W'(DATA_W-2);
    state_d  = state_q;
    idx_d    = idx_q;
    shf_d    = shf_q;
    noise_d  = noise_q;
    par_d    = par_q;
    err_d    = err_q;
    done_d   = 1'b0;
    if (!rx_en) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (start_seen) state_d = ST_START;
        ST_START: if (bit_done) begin
          if (bit_val) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_DATA;
            idx_d   = '0;
            shf_d   = '0;
            par_d   = 1'b0;
            noise_d = bit_noise;
          end
        end
        ST_DATA: if (bit_done) begin
          shf_d[idx_q] = bit_val;
          par_d   = par_q ^ bit_val;
          noise_d = noise_q | bit_noise;
          idx_d   = idx_q + IDX_W'(1);
          if (idx_q == last_idx) state_d = pen ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (bit_done) begin
          par_d   = par_q ^ bit_val;
          noise_d = noise_q | bit_noise;
          state_d = ST_STOP;
        end
        ST_STOP: if (bit_done) begin
          done_d       = 1'b1;
          err_d.frame  = !bit_val;
          err_d.noise  = noise_q | bit_noise;
          err_d.parity = pen && (par_q != podd);
          state_d      = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shf_q   <= '0;
      noise_q <= 1'b0;
      par_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      shf_q   <= shf_d;
      noise_q <= noise_d;
      par_q   <= par_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign active  = (state_q != ST_IDLE);
  assign fr_done = done_q;
  assign fr_data = shf_q;
  assign fr_err  = err_q;

  p_false_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && state_q == ST_START && bit_done && bit_val) |=> (state_q == ST_IDLE && !done_q));
  p_abandon_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (state_q == ST_IDLE && !done_q));
endmodule

// File: rtl/os_uart_rx.sv
module os_uart_rx
  import os_uart_rx_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx,
  input  logic              rx_en,
  input  logic              ovs8,
  input  logic              wl,
  input  logic              pen,
  input  logic              podd,
  input  logic              rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rbne,
  output logic              err_noise,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun
);
  logic rst_s_n, rx_s;
  logic start_seen, bit_done, bit_val, bit_noise, active, fr_done;
  logic [DATA_W-1:0] fr_data, data_q, data_d;
  rx_err_t fr_err, err_q, err_d;
  logic rbne_q, rbne_d, ovr_q, ovr_d, take, lose;

  os_uart_rx_sync #(.STAGES(2), .RST_VAL(1'b0)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_s_n));

  os_uart_rx_sync #(.STAGES(2), .RST_VAL(1'b1)) i_rx_sync (
    .clk(clk), .rst_n(rst_s_n), .d(rx), .q(rx_s));

  os_uart_rx_sampler #(.CNT_W(CNT_W)) i_sampler (
    .clk(clk), .rst_n(rst_s_n), .tick(os_tick), .ovs8(ovs8), .rx(rx_s),
    .active(active), .start_seen(start_seen), .bit_done(bit_done),
    .bit_val(bit_val), .bit_noise(bit_noise));

  os_uart_rx_framer #(.DATA_W(DATA_W)) i_framer (
    .clk(clk), .rst_n(rst_s_n), .rx_en(rx_en), .wl(wl), .pen(pen),
    .podd(podd), .start_seen(start_seen), .bit_done(bit_done),
    .bit_val(bit_val), .bit_noise(bit_noise), .active(active),
    .fr_done(fr_done), .fr_data(fr_data), .fr_err(fr_err));

  always_comb begin
    take   = fr_done && (!rbne_q || rd);
    lose   = fr_done && rbne_q && !rd;
    data_d = take ? fr_data : data_q;
    err_d  = take ? fr_err : err_q;
    rbne_d = take ? 1'b1 : (rd ? 1'b0 : rbne_q);
    ovr_d  = lose ? 1'b1 : (rd ? 1'b0 : ovr_q);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      data_q <= '0;
      err_q  <= '0;
      rbne_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      err_q  <= err_d;
      rbne_q <= rbne_d;
      ovr_q  <= ovr_d;
    end
  end

  assign rx_data     = data_q;
  assign rbne        = rbne_q;
  assign err_noise   = err_q.noise;
  assign err_parity  = err_q.parity;
  assign err_frame   = err_q.frame;
  assign err_overrun = ovr_q;

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fr_done && !rbne_q) |=> (rbne && rx_data == $past(fr_data)));
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd && !fr_done) |=> (!rbne && !err_overrun));
  p_overrun_keep_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fr_done && rbne_q && !rd) |=> (err_overrun && $stable(rx_data)));
endmodule

// File: tb/test_os_uart_rx.sv
`timescale 1ns/1ps
module test_os_uart_rx;
  logic clk = 1'b0;
  logic rst_n, os_tick, rx, rx_en, ovs8, wl, pen, podd, rd;
  logic [8:0] rx_data;
  logic rbne, err_noise, err_parity, err_frame, err_overrun;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  os_uart_rx i_os_uart_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx(rx), .rx_en(rx_en),
    .ovs8(ovs8), .wl(wl), .pen(pen), .podd(podd), .rd(rd),
    .rx_data(rx_data), .rbne(rbne), .err_noise(err_noise),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sample(input logic v);
    @(negedge clk) rx = v;
    repeat (2) @(negedge clk);
    os_tick = 1'b1;
    @(negedge clk) os_tick = 1'b0;
  endtask

  task automatic send_bit(input logic v, input int gpos);
    int len = ovs8 ? 8 : 16;
    for (int s = 1; s <= len; s++) sample((s == gpos) ? !v : v);
  endtask

  task automatic send_frame(input logic [10:0] bits, input int n, input int gbit, input int gpos);
    send_bit(1'b0, (gbit == 0) ? gpos : 0);
    for (int i = 0; i < n; i++) send_bit(bits[i], (gbit == i + 1) ? gpos : 0);
    repeat (12) sample(1'b1);
  endtask

  task automatic do_read();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R7 reset rbne", rbne, 0);
    chk("R7 reset flags", {err_noise, err_parity, err_frame, err_overrun}, 0);
  endtask

  task automatic t_basic16();
    send_frame({2'b01, 8'hA5}, 9, -1, 0);
    chk("R7 data 16x", rx_data, 9'h0A5);
    chk("R7 rbne set", rbne, 1);
    chk("R2 no noise clean", err_noise, 0);
    chk("R6 no frame err", err_frame, 0);
    do_read();
    chk("R8 read clears rbne", rbne, 0);
  endtask

  task automatic t_noise16();
    send_frame({2'b01, 8'h5A}, 9, 3, 9);
    chk("R2 majority wins", rx_data, 9'h05A);
    chk("R4 noise in window", err_noise, 1);
    do_read();
    send_frame({2'b01, 8'h5A}, 9, 3, 4);
    chk("R2 outside window data", rx_data, 9'h05A);
    chk("R2 outside window no noise", err_noise, 0);
    do_read();
  endtask

  task automatic t_ovs8();
    ovs8 = 1'b1;
    send_frame({2'b01, 8'h3C}, 9, 3, 4);
    chk("R3 8x data", rx_data, 9'h03C);
    chk("R3 8x noise at sample 4", err_noise, 1);
    do_read();
    send_frame({2'b01, 8'hC3}, 9, 5, 7);
    chk("R3 8x data2", rx_data, 9'h0C3);
    chk("R3 8x sample 7 ignored", err_noise, 0);
    do_read();
    ovs8 = 1'b0;
  endtask

  task automatic t_parity();
    logic [7:0] d = 8'h71;
    pen = 1'b1; podd = 1'b0;
    send_frame({1'b1, ^d, d}, 10, -1, 0);
    chk("R5 even ok", err_parity, 0);
    chk("R5 data with parity", rx_data, 9'h071);
    do_read();
    send_frame({1'b1, ~^d, d}, 10, -1, 0);
    chk("R5 even bad", err_parity, 1);
    do_read();
    podd = 1'b1;
    send_frame({1'b1, ~^d, d}, 10, -1, 0);
    chk("R5 odd ok", err_parity, 0);
    do_read();
    pen = 1'b0; podd = 1'b0;
  endtask

  task automatic t_9bit();
    wl = 1'b1;
    send_frame({1'b1, 9'h1A3}, 10, -1, 0);
    chk("R7 nine bits", rx_data, 9'h1A3);
    do_read();
    wl = 1'b0;
  endtask

  task automatic t_frame();
    send_frame({2'b00, 8'h96}, 9, -1, 0);
    chk("R6 frame err", err_frame, 1);
    chk("R6 data kept", rx_data, 9'h096);
    chk("R6 rbne", rbne, 1);
    do_read();
    chk("R10 no frame after bad stop", rbne, 0);
  endtask

  task automatic t_overrun();
    send_frame({2'b01, 8'h11}, 9, -1, 0);
    send_frame({2'b01, 8'h22}, 9, -1, 0);
    chk("R9 overrun flag", err_overrun, 1);
    chk("R9 old data kept", rx_data, 9'h011);
    do_read();
    chk("R8 read clears overrun", err_overrun, 0);
    chk("R8 read clears rbne", rbne, 0);
  endtask

  task automatic t_false();
    for (int s = 1; s <= 5; s++) sample(1'b0);
    repeat (27) sample(1'b1);
    chk("R10 false start ignored", rbne, 0);
    send_frame({2'b01, 8'h66}, 9, -1, 0);
    chk("R10 next frame", rx_data, 9'h066);
    do_read();
  endtask

  task automatic t_abandon();
    logic [8:0] b = {1'b1, 8'h00};
    send_bit(1'b0, 0);
    for (int i = 0; i < 3; i++) send_bit(b[i], 0);
    @(negedge clk) rx_en = 1'b0;
    for (int i = 3; i < 9; i++) send_bit(b[i], 0);
    repeat (4) sample(1'b1);
    @(negedge clk) rx_en = 1'b1;
    repeat (20) sample(1'b1);
    chk("R11 abandoned", rbne, 0);
    send_frame({2'b01, 8'h81}, 9, -1, 0);
    chk("R11 recovers", rx_data, 9'h081);
    do_read();
  endtask

  task automatic t_disabled();
    rx_en = 1'b0;
    send_frame({2'b01, 8'h00}, 9, -1, 0);
    chk("R1 disabled no frame", rbne, 0);
    rx_en = 1'b1;
    repeat (4) sample(1'b1);
  endtask

  initial begin
    rst_n = 1'b0; os_tick = 1'b0; rx = 1'b1; rx_en = 1'b1;
    ovs8 = 1'b0; wl = 1'b0; pen = 1'b0; podd = 1'b0; rd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic16();
    t_noise16();
    t_ovs8();
    t_parity();
    t_9bit();
    t_frame();
    t_overrun();
    t_false();
    t_abandon();
    t_disabled();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule